// File: doc/BRIEF.md
# Burst-splitting bus gasket

The gasket sits between one bus master and one slave port. The master hands over a whole transfer at once: a start address, a direction, a beat count, a transfer size and an incrementing or wrapping address pattern. The gasket then produces the beats on the slave side and returns one registered response per beat to the master. Three enable bits, which software sets for each master slot, decide how each transfer is presented to the slave.

When burst mode is enabled for a direction, the beats go out back to back as one burst. The first beat is marked as the start and the last beat as the end. When burst mode is disabled for that direction, every beat goes out as an independent single transfer, marked both start and end. The next single is not issued until the response of the previous one has been handed back. Burst writes report errors imprecisely: a slave error on any beat is held and shown only on the final response. A pending-read enable controls whether a new read may be accepted while the final response of the previous transfer is still being delivered.

The enable bits sit in a readback word with one byte per master slot. The mode used by a transfer is captured when its command is accepted.

Top module: `burst_gasket`

## Requirements
- R1: After reset the configuration word reads 0x07070707. In byte g (bits 8g+2..8g) bit 8g+2 is the pending-read enable, bit 8g+1 is the burst-read enable and bit 8g is the burst-write enable. A write stores those three bits of every byte. The gasket uses the byte selected by PORT_SEL, which is 0 by default.
- R2: Bits 8g+3..8g+7 of every byte always read 0, and writing ones to them changes no readback bit.
- R3: In burst mode, beats are presented on consecutive cycles while the slave is ready. s_first is 1 only on beat 0 and s_last is 1 only on the final beat. While s_ready is low, s_valid and s_addr hold.
- R4: With the burst-read enable at 0, every read beat is a single transfer (s_first=1 and s_last=1), and s_valid is low for the one cycle that follows each accepted single.
- R5: With the burst-write enable at 0, write beats are split as in R4. s_wdata carries m_wdata, and m_wnext pulses in the cycle a write beat is accepted by the slave.
- R6: With the burst-write enable at 1, every non-final write response carries err=0. The final response carries the OR of the slave errors of all beats.
- R7: Read transfers and split writes return a slave error on the response of the same beat.
- R8: With the pending-read enable at 1, a read command is accepted in the cycle in which the previous transfer's final response is on the master side. With it at 0, a read is held off until no response is pending.
- R9: Beat addresses advance by 2^size. For a wrapping transfer of N beats (N a power of two), they wrap inside the N*2^size aligned block. Otherwise they increment.
- R10: Exactly one response follows each slave acceptance, one cycle later, in beat order. It carries the slave read data (0 for writes), and rsp_last is 1 on the final beat.
- R11: A configuration write during a transfer does not alter that transfer. The new bits apply from the next accepted command.
- R12: m_cmd_ready is 0 from the cycle after a command is accepted until its final beat has been accepted by the slave.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 8*NGRP | Configuration write data |
| cfg_rdata | output | 8*NGRP | Configuration readback |
| m_cmd_valid | input | 1 | Master command valid |
| m_cmd_ready | output | 1 | Command accepted when high with valid |
| m_cmd_write | input | 1 | 1 = write, 0 = read |
| m_cmd_wrap | input | 1 | 1 = wrapping, 0 = incrementing |
| m_cmd_addr | input | AW | Start address |
| m_cmd_len | input | LW | Beats minus one |
| m_cmd_size | input | 3 | log2 of bytes per beat |
| m_wdata | input | DW | Write data of the current beat |
| m_wnext | output | 1 | Current write beat consumed |
| m_rsp_valid | output | 1 | Response valid |
| m_rsp_data | output | DW | Read data |
| m_rsp_err | output | 1 | Error response |
| m_rsp_last | output | 1 | Response of final beat |
| s_valid | output | 1 | Slave beat valid |
| s_ready | input | 1 | Slave accepts the beat |
| s_first | output | 1 | Beat starts a transaction |
| s_last | output | 1 | Beat ends a transaction |
| s_write | output | 1 | Beat direction |
| s_addr | output | AW | Beat address |
| s_size | output | 3 | Beat size |
| s_wdata | output | DW | Beat write data |
| s_rdata | input | DW | Slave read data |
| s_err | input | 1 | Slave error for the accepted beat |

## Verification
The hardest situation to reach is a configuration change landing while a transfer is in flight, together with a second read queued behind the first. Only that combination separates a mode captured at command acceptance from one read live, and shows the one-cycle difference in read acceptance. The stimulus therefore leaves the next command asserted while the current one drains, and it rewrites the enables a few cycles into a long burst. Slave errors are injected at chosen beat addresses under random slave stalls, so that imprecise and precise reporting are both exercised in stalled and unstalled beats.

// File: rtl/gasket_pkg.sv
package gasket_pkg;
  localparam int GRP_BITS = 3;
  localparam int SZW      = 3;

  typedef enum logic [0:0] {GS_IDLE, GS_RUN} gs_state_e;

  typedef struct packed {
    logic           split;
    logic           impr;
    logic           wr;
    logic           wrap;
    logic [SZW-1:0] size;
  } burst_mode_t;
endpackage

// File: rtl/gasket_cfg_regs.sv
module gasket_cfg_regs
  import gasket_pkg::*;
#(
  parameter int NGRP = 4,
  parameter int SEL  = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [8*NGRP-1:0] cfg_wdata,
  output logic [8*NGRP-1:0] cfg_rdata,
  output logic              pre,
  output logic              bre,
  output logic              bwe
);
  localparam int EW = GRP_BITS * NGRP;
  localparam int PADW = 8 - GRP_BITS;

  logic [EW-1:0] en_q;
  logic          unused_rsvd;

  assign unused_rsvd = ^cfg_wdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q <= '1;
    end else if (cfg_we) begin
      for (int g = 0; g < NGRP; g++) begin
        en_q[GRP_BITS*g +: GRP_BITS] <= cfg_wdata[8*g +: GRP_BITS];
      end
    end
  end

  for (genvar g = 0; g < NGRP; g++) begin : g_rb
    assign cfg_rdata[8*g +: 8] = {{PADW{1'b0}}, en_q[GRP_BITS*g +: GRP_BITS]};
  end

  assign pre = en_q[GRP_BITS*SEL + 2];
  assign bre = en_q[GRP_BITS*SEL + 1];
  assign bwe = en_q[GRP_BITS*SEL + 0];

  // R1: a write lands in the selected group on the next cycle
  p_cfg_write_r1: assert property (@(posedge clk) disable iff (rst)
    cfg_we |=> ({pre, bre, bwe} == $past(cfg_wdata[8*SEL +: GRP_BITS])));
endmodule

// File: rtl/gasket_addr_step.sv
module gasket_addr_step
  import gasket_pkg::*;
#(
  parameter int AW = 32,
  parameter int LW = 4
) (
  input  logic [AW-1:0]  cur,
  input  logic [SZW-1:0] size,
  input  logic [LW-1:0]  len,
  input  logic           wrap,
  output logic [AW-1:0]  nxt
);
  logic [AW-1:0] step, span, mask, inc;

  always_comb begin
    step = {{(AW-1){1'b0}}, 1'b1} << size;
    span = (AW'(len) + AW'(1)) << size;
    mask = span - AW'(1);
    inc  = cur + step;
    if (wrap) nxt = (cur & ~mask) | (inc & mask);
    else      nxt = inc;
  end
endmodule

// File: rtl/gasket_beat_ctrl.sv
module gasket_beat_ctrl
  import gasket_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int LW = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           pre,
  input  logic           bre,
  input  logic           bwe,
  input  logic           cmd_valid,
  output logic           cmd_ready,
  input  logic           cmd_write,
  input  logic           cmd_wrap,
  input  logic [AW-1:0]  cmd_addr,
  input  logic [LW-1:0]  cmd_len,
  input  logic [SZW-1:0] cmd_size,
  input  logic [DW-1:0]  wdata,
  output logic           wnext,
  output logic           rsp_valid,
  output logic [DW-1:0]  rsp_data,
  output logic           rsp_err,
  output logic           rsp_last,
  output logic           s_valid,
  input  logic           s_ready,
  output logic           s_first,
  output logic           s_last,
  output logic           s_write,
  output logic [AW-1:0]  s_addr,
  output logic [SZW-1:0] s_size,
  output logic [DW-1:0]  s_wdata,
  input  logic [DW-1:0]  s_rdata,
  input  logic           s_err
);
  gs_state_e     state;
  burst_mode_t   mode;
  logic [LW-1:0] beat, len_q;
  logic [AW-1:0] addr_q, addr_nxt;
  logic          eacc;
  logic          accept, hs, last_beat;

  gasket_addr_step #(.AW(AW), .LW(LW)) u_step (
    .cur (addr_q),
    .size(mode.size),
    .len (len_q),
    .wrap(mode.wrap),
    .nxt (addr_nxt)
  );

  assign last_beat = (beat == len_q);
  assign cmd_ready = (state == GS_IDLE) &&
                     !(cmd_valid && !cmd_write && !pre && rsp_valid);
  assign accept    = cmd_valid && cmd_ready;
  assign s_valid   = (state == GS_RUN) && !(mode.split && rsp_valid);
  assign hs        = s_valid && s_ready;
  assign s_first   = mode.split || (beat == '0);
  assign s_last    = mode.split || last_beat;
  assign s_write   = mode.wr;
  assign s_addr    = addr_q;
  assign s_size    = mode.size;
  assign s_wdata   = wdata;
  assign wnext     = hs && mode.wr;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= GS_IDLE;
      mode      <= '0;
      beat      <= '0;
      len_q     <= '0;
      addr_q    <= '0;
      eacc      <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
      rsp_err   <= 1'b0;
      rsp_last  <= 1'b0;
    end else begin
      rsp_valid <= hs;
      if (accept) begin
        state      <= GS_RUN;
        beat       <= '0;
        len_q      <= cmd_len;
        addr_q     <= cmd_addr;
        eacc       <= 1'b0;
        mode.wr    <= cmd_write;
        mode.wrap  <= cmd_wrap;
        mode.size  <= cmd_size;
        mode.split <= cmd_write ? !bwe : !bre;
        mode.impr  <= cmd_write && bwe;
      end
      if (hs) begin
        rsp_data <= mode.wr ? '0 : s_rdata;
        rsp_last <= last_beat;
        rsp_err  <= mode.impr ? (last_beat && (eacc || s_err)) : s_err;
        eacc     <= eacc || s_err;
        addr_q   <= addr_nxt;
        beat     <= beat + 1'b1;
        if (last_beat) state <= GS_IDLE;
      end
    end
  end

  // R3: a stalled beat keeps its request and address
  p_stall_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (s_valid && !s_ready) |=> (s_valid && $stable(s_addr)));

  // R4 / R5: split singles leave a gap cycle on the slave side
  p_split_gap_r4: assert property (@(posedge clk) disable iff (rst)
    (hs && mode.split) |=> !s_valid);

  // R10: every slave acceptance yields a response next cycle
  p_rsp_follows_r10: assert property (@(posedge clk) disable iff (rst)
    hs |=> rsp_valid);

  // R6: imprecise writes keep non-final responses clean
  p_imprecise_r6: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_last && mode.impr && mode.wr) |-> !rsp_err);

  // R11: mode is frozen while a transfer runs
  p_mode_frozen_r11: assert property (@(posedge clk) disable iff (rst)
    ((state == GS_RUN) && !(hs && last_beat)) |=> $stable(mode));

  // R12: no command accepted while busy
  p_busy_block_r12: assert property (@(posedge clk) disable iff (rst)
    accept |=> !cmd_ready);
endmodule

// File: rtl/burst_gasket.sv
module burst_gasket
  import gasket_pkg::*;
#(
  parameter int AW       = 32,
  parameter int DW       = 32,
  parameter int LW       = 4,
  parameter int NGRP     = 4,
  parameter int PORT_SEL = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [8*NGRP-1:0] cfg_wdata,
  output logic [8*NGRP-1:0] cfg_rdata,
  input  logic              m_cmd_valid,
  output logic              m_cmd_ready,
  input  logic              m_cmd_write,
  input  logic              m_cmd_wrap,
  input  logic [AW-1:0]     m_cmd_addr,
  input  logic [LW-1:0]     m_cmd_len,
  input  logic [2:0]        m_cmd_size,
  input  logic [DW-1:0]     m_wdata,
  output logic              m_wnext,
  output logic              m_rsp_valid,
  output logic [DW-1:0]     m_rsp_data,
  output logic              m_rsp_err,
  output logic              m_rsp_last,
  output logic              s_valid,
  input  logic              s_ready,
  output logic              s_first,
  output logic              s_last,
  output logic              s_write,
  output logic [AW-1:0]     s_addr,
  output logic [2:0]        s_size,
  output logic [DW-1:0]     s_wdata,
  input  logic [DW-1:0]     s_rdata,
  input  logic              s_err
);
  logic pre, bre, bwe;

  gasket_cfg_regs #(.NGRP(NGRP), .SEL(PORT_SEL)) u_cfg (
    .clk      (clk),
    .rst      (rst),
    .cfg_we   (cfg_we),
    .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata),
    .pre      (pre),
    .bre      (bre),
    .bwe      (bwe)
  );

  gasket_beat_ctrl #(.AW(AW), .DW(DW), .LW(LW)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .pre      (pre),
    .bre      (bre),
    .bwe      (bwe),
    .cmd_valid(m_cmd_valid),
    .cmd_ready(m_cmd_ready),
    .cmd_write(m_cmd_write),
    .cmd_wrap (m_cmd_wrap),
    .cmd_addr (m_cmd_addr),
    .cmd_len  (m_cmd_len),
    .cmd_size (m_cmd_size),
    .wdata    (m_wdata),
    .wnext    (m_wnext),
    .rsp_valid(m_rsp_valid),
    .rsp_data (m_rsp_data),
    .rsp_err  (m_rsp_err),
    .rsp_last (m_rsp_last),
    .s_valid  (s_valid),
    .s_ready  (s_ready),
    .s_first  (s_first),
    .s_last   (s_last),
    .s_write  (s_write),
    .s_addr   (s_addr),
    .s_size   (s_size),
    .s_wdata  (s_wdata),
    .s_rdata  (s_rdata),
    .s_err    (s_err)
  );
endmodule

// File: tb/sim_burst_gasket.sv
module sim_burst_gasket;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        m_cmd_valid = 1'b0, m_cmd_ready, m_cmd_write = 1'b0, m_cmd_wrap = 1'b0;
  logic [31:0] m_cmd_addr = '0;
  logic [3:0]  m_cmd_len = '0;
  logic [2:0]  m_cmd_size = '0;
  logic [31:0] m_wdata = 32'hD000_0000;
  logic        m_wnext, m_rsp_valid, m_rsp_err, m_rsp_last;
  logic [31:0] m_rsp_data;
  logic        s_valid, s_ready = 1'b1, s_first, s_last, s_write, s_err;
  logic [31:0] s_addr, s_wdata, s_rdata;
  logic [2:0]  s_size;

  bit          stall_en = 0, err_en = 0;
  logic [31:0] err_addr = '0;

  assign s_rdata = s_addr ^ 32'h5A5A_0000;
  assign s_err   = err_en && s_valid && (s_addr == err_addr);

  always #(CLK_PERIOD/2) clk = ~clk;

  burst_gasket u0 (.*);

  int nchk = 0, nfail = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // reference model state
  bit          mon = 0, mbusy, msplit, mimp, mwr, mwrap, meacc, mrv, mrerr, mrlast, wadv = 0;
  int unsigned mcfg, maddr, mlen, msize, mbeat, mrdata;

  always @(negedge clk) begin
    bit e_ready, e_sv, hs, lastb;
    int unsigned step, span;
    if (rst) begin
      mon = 1; mbusy = 0; mrv = 0; mcfg = 32'h0707_0707; wadv = 0;
      msplit = 0; mimp = 0; mwr = 0; mwrap = 0; meacc = 0; mbeat = 0; mlen = 0;
    end else if (mon) begin
      e_ready = !mbusy && !(m_cmd_valid && !m_cmd_write && !mcfg[2] && mrv);
      e_sv    = mbusy && !(msplit && mrv);
      lastb   = (mbeat == mlen);
      chk("R8/R12 cmd_ready", m_cmd_ready, e_ready);
      chk("R4/R5 s_valid", s_valid, e_sv);
      chk("R1/R2 cfg_rdata", cfg_rdata, mcfg);
      chk("R10 rsp_valid", m_rsp_valid, mrv);
      if (mrv) begin
        chk("R10 rsp_data", m_rsp_data, mrdata);
        chk("R6/R7 rsp_err", m_rsp_err, mrerr);
        chk("R10 rsp_last", m_rsp_last, mrlast);
      end
      if (e_sv) begin
        chk("R9 s_addr", s_addr, maddr);
        chk("R3/R4 s_first", s_first, msplit || mbeat == 0);
        chk("R3/R5 s_last", s_last, msplit || lastb);
        chk("R5 s_write", s_write, mwr);
        chk("R9 s_size", s_size, msize);
        if (mwr) chk("R5 s_wdata", s_wdata, m_wdata);
      end
      hs = e_sv && s_ready;
      chk("R5 m_wnext", m_wnext, hs && mwr);
      wadv = hs && mwr;
      if (hs) begin
        mrv    = 1;
        mrdata = mwr ? 0 : s_rdata;
        mrlast = lastb;
        mrerr  = mimp ? (lastb && (meacc || s_err)) : s_err;
        meacc  = meacc || s_err;
        step   = 1 << msize;
        span   = (mlen + 1) * step;
        maddr  = mwrap ? (maddr / span) * span + (maddr + step) % span : maddr + step;
        mbeat++;
        if (lastb) mbusy = 0;
      end else begin
        mrv = 0;
      end
      if (m_cmd_valid && e_ready) begin
        mbusy = 1; mbeat = 0; mlen = m_cmd_len; maddr = m_cmd_addr;
        msize = m_cmd_size; mwr = m_cmd_write; mwrap = m_cmd_wrap;
        msplit = m_cmd_write ? !mcfg[0] : !mcfg[1];
        mimp = m_cmd_write && mcfg[0]; meacc = 0;
      end
      if (cfg_we) mcfg = cfg_wdata & 32'h0707_0707;
    end
  end

  always @(posedge clk) begin
    #1;
    if (wadv) m_wdata = m_wdata + 32'h11;
    s_ready = stall_en ? (($urandom % 3) != 0) : 1'b1;
  end

  task automatic run_cmd(input bit wr, input bit wrp, input logic [31:0] a,
                         input logic [3:0] ln, input logic [2:0] sz);
    bit done = 0;
    m_cmd_valid = 1; m_cmd_write = wr; m_cmd_wrap = wrp;
    m_cmd_addr = a; m_cmd_len = ln; m_cmd_size = sz;
    while (!done) begin
      @(negedge clk);
      if (m_cmd_ready) done = 1;
      @(posedge clk); #1;
    end
    m_cmd_valid = 0;
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (!(m_cmd_ready && !m_rsp_valid));
    @(posedge clk); #1;
  endtask

  task automatic cfg_write(input logic [31:0] d);
    cfg_we = 1; cfg_wdata = d;
    @(posedge clk); #1;
    cfg_we = 0;
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #1 rst = 0;
    @(negedge clk);
    chk("R1 reset readback", cfg_rdata, 32'h0707_0707);
    chk("R12 reset ready", m_cmd_ready, 1'b1);
    @(posedge clk); #1;
    // R2: reserved bits ignored
    cfg_write(32'hFFFF_FFFF);
    @(negedge clk); chk("R2 reserved zero", cfg_rdata, 32'h0707_0707);
    @(posedge clk); #1;
    cfg_write(32'hF8F8_F8F8);
    @(negedge clk); chk("R2 reserved write only", cfg_rdata, 32'h0);
    @(posedge clk); #1;
    cfg_write(32'h0707_0707);
    // R3 R9 R10: incrementing read burst, no stalls, then with stalls
    run_cmd(0, 0, 32'h100, 4'd3, 3'd2); wait_idle();
    stall_en = 1;
    run_cmd(0, 0, 32'h200, 4'd5, 3'd1); wait_idle();
    // R9: wrapping bursts
    run_cmd(0, 1, 32'h108, 4'd3, 3'd2); wait_idle();
    run_cmd(0, 1, 32'h23, 4'd7, 3'd0); wait_idle();
    // R6: imprecise burst write, error on second beat
    err_en = 1; err_addr = 32'h304;
    run_cmd(1, 0, 32'h300, 4'd3, 3'd2); wait_idle();
    // R4 R7: split read with error on third beat
    cfg_write(32'h0000_0005);
    err_addr = 32'h408;
    run_cmd(0, 0, 32'h400, 4'd3, 3'd2); wait_idle();
    // R5 R7: split write with error
    cfg_write(32'h0000_0006);
    err_addr = 32'h504;
    run_cmd(1, 1, 32'h508, 4'd3, 3'd2); wait_idle();
    err_en = 0; stall_en = 0;
    // R8: back-to-back reads with pending reads on, then off
    cfg_write(32'h0000_0007);
    run_cmd(0, 0, 32'h600, 4'd1, 3'd2);
    run_cmd(0, 0, 32'h700, 4'd1, 3'd2); wait_idle();
    cfg_write(32'h0000_0003);
    run_cmd(0, 0, 32'h800, 4'd1, 3'd2);
    run_cmd(0, 0, 32'h900, 4'd1, 3'd2);
    run_cmd(1, 0, 32'hA00, 4'd1, 3'd2); wait_idle();
    // R11: config change in mid-burst
    cfg_write(32'h0000_0007);
    run_cmd(0, 0, 32'hB00, 4'd7, 3'd2);
    cfg_write(32'h0000_0004);
    wait_idle();
    run_cmd(0, 0, 32'hC00, 4'd3, 3'd2); wait_idle();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog expired (R12 progress) actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
    $finish;
  end
endmodule